// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

An eight-channel timer block that produces periodic time-out events for software. Each channel owns a 16-bit reload value and a 16-bit down-counter. A global run bit gates the whole block, and a per-channel start bit arms each channel. When a channel starts, its counter takes the reload value. The counter then steps down on ticks from one of two shared 8-bit prescalers, chosen per channel. When a step arrives while the counter is at zero, the channel raises a sticky time-out flag and reloads in the same cycle.

Software talks to the block over a simple synchronous word bus. A write takes effect at the clock edge on which `req_i` and `we_i` are high. Read data is combinational from the address while `req_i` is high and `we_i` is low. A write-only strobe register reloads selected counters at once. Each flag is cleared by writing one to it, and each flag drives an interrupt line through its own mask bit.

Top module: `pit_timer`

## Requirements
- R1: After reset, every register and counter reads zero and `irq_o` is zero. The word addresses are: 0 control (bit 0 is the global run bit), 1 channel start, 2 force reload, 3 tick-source select, 4 interrupt mask, 5 time-out flags, 6 and 7 the reload values of prescalers 0 and 1, 8+2n the reload value of channel n, 9+2n the counter of channel n (read-only). Bit n of registers 1 to 5 belongs to channel n, and unused addresses read zero.
- R2: The start, select, mask, reload and prescaler registers read back the last value written to them, at any time.
- R3: One cycle after a channel's start bit and the run bit are both first seen high, the channel's counter holds its reload value.
- R4: A running prescaler ticks once every (reload+1) cycles. Select bit n = 0 feeds channel n from prescaler 0, and select bit n = 1 feeds it from prescaler 1. While the run bit is low, the prescalers reload and do not tick.
- R5: On a selected tick, a running counter that is nonzero decrements. A running counter that is zero sets its flag and takes its reload value in the same cycle. A flag rises only on such a tick.
- R6: Writing 1 to bit n of the force-reload register copies reload value n into counter n, but only while channel n and the run bit are both on. Otherwise the write is ignored, a 0 bit does nothing, and the register always reads zero.
- R7: A force reload in the same cycle as a tick wins: the counter takes the reload value and the flag is not set.
- R8: While a channel's start bit is low, its counter holds and its flag is cleared.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A time-out in the same cycle wins over the clear.
- R10: `irq_o[n]` is high exactly when flag n and mask bit n are both set.
- R11: While the run bit is low, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| irq_o | output | 8 | Per-channel interrupt request |

## Verification
The assertions check four things on every cycle. A stopped channel's counter stays frozen and its flag stays low. A flag only rises out of a zero-count tick. A prescaler with a nonzero reload never ticks on two cycles in a row. The force-reload address always reads zero. The bench's scenarios are what show the exact counter values: the start load, the reload after a time-out, force reload beating a tick, flag clear-on-write, gating by the run bit, and source selection. The bench follows these against a cycle model built from the requirements while random register traffic runs.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned NUM_SRC   = 2;
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_CHEN    = 1;
  localparam int unsigned A_FLOAD   = 2;
  localparam int unsigned A_MUX     = 3;
  localparam int unsigned A_IEN     = 4;
  localparam int unsigned A_FLAG    = 5;
  localparam int unsigned A_PRE     = 6;  // NUM_SRC consecutive words
  localparam int unsigned A_CH_BASE = 8;  // reload at +2n, counter at +2n+1
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] ld_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick_o  = en_i & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || at_zero)  cnt_q <= ld_i;
    else                        cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_i,
  input  logic             ce_i,
  input  logic             tick_i,
  input  logic             fload_i,
  input  logic             fclr_i,
  input  logic [CNT_W-1:0] ld_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic run, run_q, reload, step, timeout;
  logic [CNT_W-1:0] cnt_q;
  logic flag_q;

  assign run     = gen_i & ce_i;
  assign reload  = run & (~run_q | fload_i);  // start or forced reload beats tick
  assign step    = run & ~reload & tick_i;
  assign timeout = step & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      run_q <= run;
      if (reload || timeout) cnt_q <= ld_i;
      else if (step)         cnt_q <= cnt_q - 1'b1;
      if (!ce_i)             flag_q <= 1'b0;
      else if (timeout)      flag_q <= 1'b1;
      else if (fclr_i)       flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NCH-1:0][CNT_W-1:0]     cnt_i,
  input  logic [NCH-1:0]                flag_i,
  output logic                          gen_o,
  output logic [NCH-1:0]                chen_o,
  output logic [NCH-1:0]                mux_o,
  output logic [NCH-1:0]                ien_o,
  output logic [NCH-1:0]                fload_o,
  output logic [NCH-1:0]                fclr_o,
  output logic [NUM_SRC-1:0][PRE_W-1:0] pre_ld_o,
  output logic [NCH-1:0][CNT_W-1:0]     ld_o,
  output logic [DATA_W-1:0]             rdata_o
);
  logic wr, rd;
  logic gen_q;
  logic [NCH-1:0] chen_q, mux_q, ien_q;
  logic [NUM_SRC-1:0][PRE_W-1:0] pre_q;
  logic [NCH-1:0][CNT_W-1:0] ld_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned loc);
    return a == ADDR_W'(loc);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q  <= 1'b0;
      chen_q <= '0;
      mux_q  <= '0;
      ien_q  <= '0;
      pre_q  <= '0;
      ld_q   <= '0;
    end else if (wr) begin
      if (hit(addr_i, A_CTRL)) gen_q  <= wdata_i[0];
      if (hit(addr_i, A_CHEN)) chen_q <= wdata_i[NCH-1:0];
      if (hit(addr_i, A_MUX))  mux_q  <= wdata_i[NCH-1:0];
      if (hit(addr_i, A_IEN))  ien_q  <= wdata_i[NCH-1:0];
      for (int p = 0; p < NUM_SRC; p++)
        if (hit(addr_i, A_PRE + p)) pre_q[p] <= wdata_i[PRE_W-1:0];
      for (int n = 0; n < NCH; n++)
        if (hit(addr_i, A_CH_BASE + 2*n)) ld_q[n] <= wdata_i[CNT_W-1:0];
    end
  end

  // one-cycle strobes, never stored
  assign fload_o = (wr && hit(addr_i, A_FLOAD)) ? wdata_i[NCH-1:0] : '0;
  assign fclr_o  = (wr && hit(addr_i, A_FLAG))  ? wdata_i[NCH-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (hit(addr_i, A_CTRL)) rdata_o = DATA_W'(gen_q);
      if (hit(addr_i, A_CHEN)) rdata_o = DATA_W'(chen_q);
      if (hit(addr_i, A_MUX))  rdata_o = DATA_W'(mux_q);
      if (hit(addr_i, A_IEN))  rdata_o = DATA_W'(ien_q);
      if (hit(addr_i, A_FLAG)) rdata_o = DATA_W'(flag_i);
      for (int p = 0; p < NUM_SRC; p++)
        if (hit(addr_i, A_PRE + p)) rdata_o = DATA_W'(pre_q[p]);
      for (int n = 0; n < NCH; n++) begin
        if (hit(addr_i, A_CH_BASE + 2*n))     rdata_o = DATA_W'(ld_q[n]);
        if (hit(addr_i, A_CH_BASE + 2*n + 1)) rdata_o = DATA_W'(cnt_i[n]);
      end
    end
  end

  assign gen_o    = gen_q;
  assign chen_o   = chen_q;
  assign mux_o    = mux_q;
  assign ien_o    = ien_q;
  assign pre_ld_o = pre_q;
  assign ld_o     = ld_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    irq_o
);
  logic                          gen;
  logic [NCH-1:0]                chen, mux_sel, ien, fload, fclr, flags;
  logic [NUM_SRC-1:0][PRE_W-1:0] pre_ld;
  logic [NUM_SRC-1:0]            ticks;
  logic [NCH-1:0][CNT_W-1:0]     ld, cnt;

  pit_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .flag_i(flags),
    .gen_o(gen), .chen_o(chen), .mux_o(mux_sel), .ien_o(ien),
    .fload_o(fload), .fclr_o(fclr), .pre_ld_o(pre_ld), .ld_o(ld),
    .rdata_o
  );

  for (genvar p = 0; p < NUM_SRC; p++) begin : g_pre
    pit_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i, .rst_ni, .en_i(gen), .ld_i(pre_ld[p]), .tick_o(ticks[p])
    );
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pit_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni,
      .gen_i(gen), .ce_i(chen[n]), .tick_i(ticks[mux_sel[n]]),
      .fload_i(fload[n]), .fclr_i(fclr[n]), .ld_i(ld[n]),
      .cnt_o(cnt[n]), .flag_o(flags[n])
    );
  end

  assign irq_o = flags & ien;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [DATA_W-1:0]             rdata_i,
  input logic [NCH-1:0]                chen_i,
  input logic [NCH-1:0]                mux_i,
  input logic [NUM_SRC-1:0]            ticks_i,
  input logic [NUM_SRC-1:0][PRE_W-1:0] pre_ld_i,
  input logic [NCH-1:0][CNT_W-1:0]     cnt_i,
  input logic [NCH-1:0]                flag_i
);
  AST_FLOAD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(A_FLOAD)) |-> rdata_i == '0); // R6

  for (genvar p = 0; p < NUM_SRC; p++) begin : g_pre
    AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ticks_i[p] && pre_ld_i[p] != '0) |=> !ticks_i[p]); // R4
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chen_i[n] |=> $stable(cnt_i[n])); // R8
    AST_STOPPED_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chen_i[n] |=> !flag_i[n]); // R8
    AST_FLAG_FROM_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[n]) |-> $past(ticks_i[mux_i[n]] && cnt_i[n] == '0)); // R5
  end
endmodule

bind pit_timer pit_timer_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_i(rdata_o), .chen_i(chen), .mux_i(mux_sel), .ticks_i(ticks),
  .pre_ld_i(pre_ld), .cnt_i(cnt), .flag_i(flags)
);

// File: tb/pit_timer_test.sv
module pit_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  irq;
  int checks = 0, fails = 0;
  bit done = 0, live = 0;

  pit_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  // cycle model written from the requirements
  bit          m_gen;
  logic [7:0]  m_ce, m_mux, m_ien, m_flag, m_runq;
  logic [7:0]  m_psl [2];
  logic [7:0]  m_psc [2];
  logic [15:0] m_ld  [8];
  logic [15:0] m_cnt [8];

  task automatic model_reset();
    m_gen = 0; m_ce = 0; m_mux = 0; m_ien = 0; m_flag = 0; m_runq = 0;
    for (int p = 0; p < 2; p++) begin m_psl[p] = 0; m_psc[p] = 0; end
    for (int n = 0; n < 8; n++) begin m_ld[n] = 0; m_cnt[n] = 0; end
  endtask

  task automatic model_step();
    logic [1:0] tk;
    logic [7:0] fl, fc;
    bit wr, run, to;
    wr = req && we;
    fl = (wr && addr == 2) ? wdata[7:0] : 8'h0;
    fc = (wr && addr == 5) ? wdata[7:0] : 8'h0;
    for (int p = 0; p < 2; p++) begin
      tk[p] = m_gen && m_psc[p] == 0;
      m_psc[p] = (!m_gen || m_psc[p] == 0) ? m_psl[p] : m_psc[p] - 8'd1;
    end
    for (int n = 0; n < 8; n++) begin
      run = m_gen && m_ce[n];
      to = 0;
      if (run && (!m_runq[n] || fl[n])) m_cnt[n] = m_ld[n];
      else if (run && tk[m_mux[n]]) begin
        if (m_cnt[n] == 0) begin to = 1; m_cnt[n] = m_ld[n]; end
        else m_cnt[n] = m_cnt[n] - 16'd1;
      end
      if (!m_ce[n]) m_flag[n] = 0;
      else if (to) m_flag[n] = 1;
      else if (fc[n]) m_flag[n] = 0;
      m_runq[n] = run;
    end
    if (wr) begin
      case (addr)
        0: m_gen = wdata[0];
        1: m_ce = wdata[7:0];
        3: m_mux = wdata[7:0];
        4: m_ien = wdata[7:0];
        6: m_psl[0] = wdata[7:0];
        7: m_psl[1] = wdata[7:0];
        default: if (addr >= 8 && addr < 24 && !addr[0]) m_ld[(addr - 8) >> 1] = wdata;
      endcase
    end
  endtask

  function automatic logic [15:0] mread(input logic [4:0] a);
    case (a)
      0: return {15'h0, m_gen};
      1: return {8'h0, m_ce};
      3: return {8'h0, m_mux};
      4: return {8'h0, m_ien};
      5: return {8'h0, m_flag};
      6: return {8'h0, m_psl[0]};
      7: return {8'h0, m_psl[1]};
      default: begin
        if (a >= 8 && a < 24) return a[0] ? m_cnt[(a - 8) >> 1] : m_ld[(a - 8) >> 1];
        return 16'h0;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      0: return "R11";
      1, 6, 7: return "R2";
      2: return "R6";
      3: return "R4";
      4: return "R10";
      5: return "R9";
      default: return (a >= 8 && a < 24 && a[0]) ? "R5" : "R2";
    endcase
  endfunction

  always @(posedge clk) if (rst_n) model_step();

  task automatic check(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (live) check(irq === (m_flag & m_ien), "R10", {8'h0, irq}, {8'h0, m_flag & m_ien});

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    req = 1; we = 0; addr = a;
    #1 check(rdata === mread(a), tag_of(a), rdata, mread(a));
    @(negedge clk);
    req = 0;
  endtask

  task automatic rd_lit(input logic [4:0] a, input logic [15:0] exp, input string rq);
    req = 1; we = 0; addr = a;
    #1 check(rdata === exp && exp === mread(a), rq, rdata, exp);
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    model_reset();
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    // R1: reset state on every address
    for (int a = 0; a < 32; a++) rd_lit(5'(a), 16'h0, "R1");
    check(irq === 8'h0, "R1", {8'h0, irq}, 16'h0);
    // directed: channel 0, tick every cycle, reload 2
    wr(6, 0); wr(0, 1); wr(8, 2); wr(4, 1);
    wr(1, 1);                       // start bit lands
    idle(1);                        // start load edge
    rd_lit(9, 2, "R3");
    idle(1);                        // counter now 0
    wr(2, 1);                       // force reload coincides with tick at zero
    rd_lit(9, 2, "R7");
    rd_lit(5, 0, "R7");
    idle(1);                        // time-out edge
    rd_lit(5, 1, "R5");
    check(irq === 8'h01, "R10", {8'h0, irq}, 16'h1);
    rd_lit(9, 1, "R5");
    wr(2, 0);                       // zero bits do nothing
    rd(9);
    wr(1, 0);                       // stop channel
    idle(1);
    rd_lit(5, 0, "R8");
    rd(9); idle(3); rd(9);          // R8 counter holds
    wr(2, 1); rd(9);                // R6 ignored while stopped
    // constrained random traffic
    for (int i = 0; i < 5000; i++) begin
      case ($urandom % 16)
        0, 1: wr(1, 16'($urandom % 256));
        2:    wr(2, 16'($urandom % 256));
        3:    wr(3, 16'($urandom % 256));
        4:    wr(4, 16'($urandom % 256));
        5:    wr(5, 16'($urandom % 256));
        6:    wr(5'(6 + $urandom % 2), 16'($urandom % 4));
        7:    wr(5'(8 + 2 * ($urandom % 8)), 16'($urandom % 12));
        8:    wr(0, 16'(($urandom % 8) != 0));
        9, 10, 11, 12, 13: rd(5'($urandom % 32));
        default: idle(1);
      endcase
    end
    // R11: run bit low freezes all counters
    wr(1, 16'hff); wr(0, 0);
    for (int n = 0; n < 8; n++) rd(5'(9 + 2 * n));
    idle(5);
    for (int n = 0; n < 8; n++) rd(5'(9 + 2 * n));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule